// File: doc/BRIEF.md
# Exhaustive-Service Round-Robin VOQ Matcher

This block schedules the crossbar of an N-by-N cell switch whose inputs keep one queue for each output. Each time slot (one clock cycle) it reads the occupancy of all N×N queues and produces a set of input-to-output connections in which no output is used twice. Free ports are matched by a single pass of request, grant and accept, resolved at each output and each input by a rotating round-robin priority.

Once an input and an output are joined, the pair stays connected in the following slots and the queue drains without interruption, so the slots spent forming the match are shared by every cell of that queue. The pair lets go when its queue reads empty. If the `SVC_LIMIT` parameter is non-zero, it also lets go after that many consecutive slots. A released pair sits out one slot, and its ports compete again in the slot after it.

The match for a slot is a combinational function of that slot's counts and the registered lock and pointer state. The external datapath moves one cell per valid match, and it updates the counts before the next slot.

Top module: `voqsch_top`

## Requirements
- R1: Reset clears every lock and sets every grant and accept pointer to index 0. With all counts zero, `match_vld` is all zeros and `match_out` is all zeros.
- R2: Input i requests output j only if i and j are both unlocked and the count at `voq_cnt[(i*N+j)*CW +: CW]` is non-zero. A pair whose count is zero is never shown as matched.
- R3: An output with several requests grants the first requesting input found by scanning upward from its grant pointer, wrapping modulo N.
- R4: An output's grant pointer moves to (granted input + 1) mod N only when the input accepts that grant. Otherwise it keeps its value.
- R5: An input with several grants accepts the first granting output found by scanning upward from its accept pointer, wrapping modulo N. The accept pointer then moves to (accepted output + 1) mod N.
- R6: With `SVC_LIMIT` = 0, a matched pair is shown again in every following slot in which its count is non-zero. Requests from other ports to either of its ports have no effect during that time.
- R7: In the slot where a locked pair's count reads zero, that input shows no match. Neither of its ports takes part in arbitration in that slot, and both compete again from the next slot.
- R8: With `SVC_LIMIT` = L > 0, a pair is shown for at most L consecutive slots. It is then released for one slot, as in R7, even if cells remain.
- R9: Bit i of `match_vld` flags a match for input i. Field `match_out[i*IW +: IW]` holds the matched output index, and the field is zero when the bit is clear. No output appears in two valid fields in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| voq_cnt | input | N*N*CW | Queue occupancy; queue (i,j) at bits (i*N+j)*CW +: CW |
| match_vld | output | N | Per-input match valid for the current slot |
| match_out | output | N*IW | Per-input matched output index, IW bits each |

## Verification
The bench builds two copies, both with N = 4 and CW = 4. The first has `SVC_LIMIT` = 0, which is pure exhaustive service. It exercises locking against competing requests, release on an empty queue, and the rotation of the grant and accept pointers across several contention rounds. The second has `SVC_LIMIT` = 2, which makes a cap expire within a few slots. This shows the forced release of a pair that still holds cells, the hand-over to the next input in rotation, and a mid-run reset that returns the pointers to zero.

// File: rtl/voqsch_pkg.sv
package voqsch_pkg;

    // Disposition of a locked pair in the current slot
    typedef enum logic [1:0] {
        HOLD_IDLE    = 2'd0,
        HOLD_KEEP    = 2'd1,
        HOLD_DRAINED = 2'd2,
        HOLD_CAPPED  = 2'd3
    } hold_e;

    // Modulo-n increment for rotating pointers
    function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/voqsch_rr_pick.sv
module voqsch_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the pointer upward; the lowest offset wins, so walk offsets downward
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned pos;
            pos = (int'(ptr) + k) % N;
            if (req[pos]) begin
                hit = 1'b1;
                idx = IW'(pos);
            end
        end
    end
endmodule

// File: rtl/voqsch_pair_lock.sv
module voqsch_pair_lock
    import voqsch_pkg::*;
#(
    parameter int N     = 4,
    parameter int IW    = 2,
    parameter int CW    = 4,
    parameter int LIMIT = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N*CW-1:0] row_cnt,
    input  logic            new_vld,
    input  logic [IW-1:0]   new_out,
    output logic            show_vld,
    output logic [IW-1:0]   show_out,
    output logic            lock_vld,
    output logic [IW-1:0]   lock_out
);
    localparam int SW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;

    logic [SW-1:0] served;
    logic [CW-1:0] cur_cnt;
    hold_e         hold;

    assign cur_cnt = row_cnt[int'(lock_out)*CW +: CW];

    always_comb begin
        if (!lock_vld)
            hold = HOLD_IDLE;
        else if (cur_cnt == '0)
            hold = HOLD_DRAINED;
        else if (LIMIT != 0 && int'(served) >= LIMIT)
            hold = HOLD_CAPPED;
        else
            hold = HOLD_KEEP;
    end

    assign show_vld = (hold == HOLD_KEEP) || new_vld;
    assign show_out = (hold == HOLD_KEEP) ? lock_out : (new_vld ? new_out : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_vld <= 1'b0;
            lock_out <= '0;
            served   <= '0;
        end else begin
            lock_vld <= show_vld;
            if (new_vld) begin
                lock_out <= new_out;
                served   <= SW'(1);
            end else if (hold == HOLD_KEEP && LIMIT != 0) begin
                served   <= served + SW'(1);
            end
        end
    end
endmodule

// File: rtl/voqsch_top.sv
module voqsch_top
    import voqsch_pkg::*;
#(
    parameter int N         = 4,
    parameter int CW        = 4,
    parameter int SVC_LIMIT = 0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N*N*CW-1:0]             voq_cnt,
    output logic [N-1:0]                  match_vld,
    output logic [N*((N>1)?$clog2(N):1)-1:0] match_out
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  lock_vld;
    logic [IW-1:0] lock_out [N];
    logic [N-1:0]  out_busy;
    logic [N-1:0]  req_io   [N];   // [input][output]
    logic [N-1:0]  col_req  [N];   // [output][input]
    logic [N-1:0]  gnt_hit;
    logic [IW-1:0] gnt_idx  [N];
    logic [N-1:0]  gnt_to   [N];   // [input][output]
    logic [N-1:0]  acc_hit;
    logic [IW-1:0] acc_idx  [N];
    logic [IW-1:0] gptr     [N];
    logic [IW-1:0] aptr     [N];

    // Outputs held by a locked pair
    always_comb begin
        for (int j = 0; j < N; j++) begin
            out_busy[j] = 1'b0;
            for (int i = 0; i < N; i++)
                if (lock_vld[i] && int'(lock_out[i]) == j)
                    out_busy[j] = 1'b1;
        end
    end

    // Request phase
    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                req_io[i][j]  = !lock_vld[i] && !out_busy[j] &&
                                (voq_cnt[(i*N+j)*CW +: CW] != '0);
                col_req[j][i] = req_io[i][j];
            end
    end

    // Grant phase fan-out to inputs
    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                gnt_to[i][j] = gnt_hit[j] && int'(gnt_idx[j]) == i;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_port
            voqsch_rr_pick #(.N(N), .IW(IW)) u_grant (
                .req (col_req[g]),
                .ptr (gptr[g]),
                .hit (gnt_hit[g]),
                .idx (gnt_idx[g])
            );

            voqsch_rr_pick #(.N(N), .IW(IW)) u_accept (
                .req (gnt_to[g]),
                .ptr (aptr[g]),
                .hit (acc_hit[g]),
                .idx (acc_idx[g])
            );

            logic [IW-1:0] show_out;

            voqsch_pair_lock #(.N(N), .IW(IW), .CW(CW), .LIMIT(SVC_LIMIT)) u_lock (
                .clk      (clk),
                .rst      (rst),
                .row_cnt  (voq_cnt[g*N*CW +: N*CW]),
                .new_vld  (acc_hit[g]),
                .new_out  (acc_idx[g]),
                .show_vld (match_vld[g]),
                .show_out (show_out),
                .lock_vld (lock_vld[g]),
                .lock_out (lock_out[g])
            );

            assign match_out[g*IW +: IW] = match_vld[g] ? show_out : '0;

            // Accept pointer: past the accepted output
            always_ff @(posedge clk) begin
                if (rst)
                    aptr[g] <= '0;
                else if (acc_hit[g])
                    aptr[g] <= IW'(wrap_inc(32'(acc_idx[g]), N));
            end

            // Grant pointer: past the granted input, only if it accepted
            always_ff @(posedge clk) begin
                if (rst)
                    gptr[g] <= '0;
                else if (gnt_hit[g] && acc_hit[gnt_idx[g]] &&
                         int'(acc_idx[gnt_idx[g]]) == g)
                    gptr[g] <= IW'(wrap_inc(32'(gnt_idx[g]), N));
            end
        end
    endgenerate
endmodule

// File: rtl/voqsch_chk.sv
module voqsch_chk #(
    parameter int N         = 4,
    parameter int CW        = 4,
    parameter int SVC_LIMIT = 0
) (
    input logic                          clk,
    input logic                          rst,
    input logic [N*N*CW-1:0]             voq_cnt,
    input logic [N-1:0]                  match_vld,
    input logic [N*((N>1)?$clog2(N):1)-1:0] match_out
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  prev_vld;
    logic [IW-1:0] prev_out [N];
    logic [15:0]   run      [N];
    logic          conflict;

    always_comb begin
        conflict = 1'b0;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                if (match_vld[a] && match_vld[b] &&
                    match_out[a*IW +: IW] == match_out[b*IW +: IW])
                    conflict = 1'b1;
    end

    // R9: one input per output
    a_r9_no_shared_output: assert property (@(posedge clk) disable iff (rst)
        !conflict);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_in
            logic [IW-1:0] cur_o;
            logic [CW-1:0] cnt_now;
            logic [CW-1:0] cnt_prev;

            assign cur_o    = match_out[g*IW +: IW];
            assign cnt_now  = voq_cnt[(g*N + int'(cur_o))*CW +: CW];
            assign cnt_prev = voq_cnt[(g*N + int'(prev_out[g]))*CW +: CW];

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_vld[g] <= 1'b0;
                    prev_out[g] <= '0;
                    run[g]      <= '0;
                end else begin
                    prev_vld[g] <= match_vld[g];
                    prev_out[g] <= cur_o;
                    if (!match_vld[g])
                        run[g] <= '0;
                    else if (prev_vld[g] && prev_out[g] == cur_o)
                        run[g] <= run[g] + 16'd1;
                    else
                        run[g] <= 16'd1;
                end
            end

            a_r2_match_needs_cells: assert property (@(posedge clk) disable iff (rst)
                match_vld[g] |-> (cnt_now != '0));

            a_r6_hold_while_nonempty: assert property (@(posedge clk) disable iff (rst)
                (SVC_LIMIT == 0 && prev_vld[g] && cnt_prev != '0) |->
                (match_vld[g] && cur_o == prev_out[g]));

            a_r7_idle_after_drain: assert property (@(posedge clk) disable iff (rst)
                (prev_vld[g] && cnt_prev == '0) |-> !match_vld[g]);

            a_r8_run_within_limit: assert property (@(posedge clk) disable iff (rst)
                (SVC_LIMIT == 0) || (int'(run[g]) <= SVC_LIMIT));
        end
    endgenerate
endmodule

bind voqsch_top voqsch_chk #(.N(N), .CW(CW), .SVC_LIMIT(SVC_LIMIT)) u_chk (.*);

// File: tb/tb_voqsch_top.sv
module tb_voqsch_top;
    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int CW    = 4;
    localparam int IW    = 2;
    localparam int NV    = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N*N*CW-1:0] cnt_a = '0;
    logic [N*N*CW-1:0] cnt_b = '0;
    logic [N-1:0]      vld_a, vld_b;
    logic [N*IW-1:0]   out_a, out_b;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    voqsch_top #(.N(N), .CW(CW), .SVC_LIMIT(0)) dut (
        .clk(clk), .rst(rst), .voq_cnt(cnt_a), .match_vld(vld_a), .match_out(out_a));

    voqsch_top #(.N(N), .CW(CW), .SVC_LIMIT(2)) dut_lim (
        .clk(clk), .rst(rst), .voq_cnt(cnt_b), .match_vld(vld_b), .match_out(out_b));

    // Counts: nibble k = i*4+j; hex groups read input3..input0, each output3..output0
    localparam logic [63:0] V_CNT [NV] = '{
        64'h0000_0300_0001_0012,  // 0 R5: in0 granted by out0 and out1, takes out0
        64'h0000_0200_0001_0011,  // 1 R6/R9: locks hold, in1 ignored
        64'h0000_0100_0001_0010,  // 2 R7: in0 drained, sits out
        64'h0000_0000_0001_0010,  // 3 R4: out0 pointer advanced to in1
        64'h0000_0000_0000_0000,  // 4 R7: both drained
        64'h0001_0001_0001_0001,  // 5 R3: out0 pointer at 2
        64'h0001_0000_0001_0001,  // 6 R7: out0 idle for a slot
        64'h0001_0000_0001_0001,  // 7 R4: out0 pointer at 3
        64'h0000_0000_0000_0000,  // 8 R7
        64'h0000_0000_0000_1111,  // 9 R5: in0 accept pointer at 2
        64'h0000_0000_0000_0000   // 10 R2: nothing to match
    };
    localparam logic [3:0] V_VLD [NV] = '{
        4'h5, 4'h5, 4'h4, 4'h3, 4'h0, 4'h4, 4'h0, 4'h8, 4'h0, 4'h1, 4'h0 };
    localparam logic [7:0] V_OUT [NV] = '{
        8'h20, 8'h20, 8'h20, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00 };
    localparam string V_TAG [NV] = '{
        "R5", "R6/R9", "R7", "R4", "R7", "R3", "R7", "R4", "R7", "R5", "R2" };

    task automatic check(string tag, logic [3:0] gv, logic [3:0] ev,
                         logic [7:0] go, logic [7:0] eo);
        n_chk++;
        if (gv !== ev || go !== eo) begin
            n_bad++;
            $display("FAIL %s: vld=%h out=%h expected vld=%h out=%h", tag, gv, go, ev, eo);
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 reset a", vld_a, 4'h0, out_a, 8'h00);
        check("R1 reset b", vld_b, 4'h0, out_b, 8'h00);

        for (int v = 0; v < NV; v++) begin
            @(posedge clk);
            #1 cnt_a = V_CNT[v];
            @(negedge clk);
            check(V_TAG[v], vld_a, V_VLD[v], out_a, V_OUT[v]);
        end

        // R8: cap of 2 on dut_lim, in0 and in1 both queue cells for out0
        @(posedge clk);
        #1 cnt_b = 64'h0000_0000_0005_0005;
        @(negedge clk);
        check("R8 first slot", vld_b, 4'h1, out_b, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R8 second slot", vld_b, 4'h1, out_b, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R8 capped release", vld_b, 4'h0, out_b, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R8 next input", vld_b, 4'h2, out_b, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R8 continued", vld_b, 4'h2, out_b, 8'h00);

        // R1: reset mid-run returns out0 grant pointer to input 0
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 pointer reset", vld_b, 4'h1, out_b, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule